// File: doc/BRIEF.md
# Cascaded Interrupt Controller Tree

This block collects 32 interrupt request lines through four 8-input slave priority units. Each slave feeds one input of an 8-input master priority unit. The master also takes one direct bridge request. The processor sees a single request output. It also sees the 5-bit number of the winning tree line, or a flag when the bridge input wins. The processor acknowledges the request through a strobe. It retires the request by writing a specific end-of-interrupt byte, first to the owning slave and then to the master.

Software uses a small byte-wide register port. Through it, software sets one mask byte per slave and selects level or edge triggering for a sparse set of the lines. Software can also read back the in-service bytes, the master request vector and each slave's pending byte. Edge-triggered lines latch a rising edge until it is acknowledged. Level-triggered lines request only while their input is high. Priority is fixed in every unit, and a lower index wins. An in-service bit holds off its own line and every lower-priority line of that unit.

Top module: `irq_cascade_tree`

## Requirements
- R1: After reset, every slave mask byte reads 0xFF, every in-service byte and both trigger bytes read 0x00, and no request is raised even when lines pulse.
- R2: Tree line n belongs to slave n/8, at bit n%8. Slaves 0, 1, 2 and 3 drive master inputs 1, 3, 4 and 5, and master input 0 is the bridge request. When a tree line wins, `irqLine` equals n. Acknowledging it sets bit n%8 of slave n/8's in-service byte and the master bit of that slave's input.
- R3: A mask bit of 1 blocks its line and a 0 enables it. A masked edge line still latches its edge, which shows in the pending byte, and it requests as soon as it is unmasked.
- R4: A line in edge mode latches a rising edge. The request remains after the input falls, until the line is acknowledged.
- R5: Setting trigger byte 0 (address 10) bits 0..4 puts tree lines 10..14 (EISA IRQ 3..7) in level mode. Bits 5..7 do the same for lines 16..18 (EISA IRQ 9..11). Trigger byte 1 (address 11) bit 0 selects line 19 (EISA IRQ 12), and bits 1..2 select lines 21..22 (EISA IRQ 14..15). Bits 7..3 of byte 1 read 0, and all other lines are always edge mode. A level line requests exactly while its input is high, and it requests again after its end-of-interrupt if the input is still high.
- R6: The lowest-numbered requesting line wins, and an active bridge request beats every tree line. When the bridge wins, `irqFromBridge` is 1.
- R7: `ackStrobe` while `irqOut` is high moves the winner into service and clears its edge latch. `ackStrobe` while `irqOut` is low changes nothing.
- R8: A set in-service bit blocks its own input and all higher-index inputs of that unit. A tree line therefore stays blocked after the slave end-of-interrupt until the master end-of-interrupt.
- R9: Writing 0xE0|i to a slave command address (4+k) or to the master command address (8) clears in-service bit i of that unit. A byte whose top five bits are not 11100 is ignored.
- R10: The address map is as follows:
  - 0..3 are the slave masks (read/write).
  - 4..7 are the slave commands, and a read returns that slave's in-service byte.
  - 8 is the master command, and a read returns the master in-service byte.
  - 9 reads the master request vector.
  - 10 and 11 are the trigger bytes.
  - 12..15 read the slave pending bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqLines | input | 32 | Tree request lines |
| bridgeReq | input | 1 | Direct bridge request on master input 0 (level) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| ackStrobe | input | 1 | Processor acknowledge |
| irqOut | output | 1 | Interrupt request to the processor |
| irqFromBridge | output | 1 | Winner is the bridge input |
| irqLine | output | 5 | Winning tree line number |

## Verification
The bench builds the block with its default shape of four slaves of eight lines and the fixed sparse trigger map. This shape is small enough for complete sweeps. Every one of the 32 lines goes through the full cycle: latch, acknowledge, slave retire and master retire. All 496 ordered line pairs test priority and nested blocking. Each of the 11 trigger bits is tried alone against every line, which confirms that exactly one line turns level-sensitive.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int UNIT_W    = 8;
  localparam int SLAVE_N   = 4;
  localparam int LINE_N    = UNIT_W * SLAVE_N;
  localparam int LINE_W    = $clog2(LINE_N);
  localparam int IDX_W     = $clog2(UNIT_W);
  localparam int SLAVE_W   = $clog2(SLAVE_N);
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int TRIG_HI_W = 3;
  localparam int EISA_BASE = 7;
  localparam logic [4:0] EOI_TAG = 5'b11100;

  // address groups, selected by regAddr[3:2]
  localparam logic [1:0] GRP_MASK = 2'b00;
  localparam logic [1:0] GRP_SCMD = 2'b01;
  localparam logic [1:0] GRP_MISC = 2'b10;
  localparam logic [1:0] GRP_PEND = 2'b11;
  localparam logic [1:0] MISC_MCMD  = 2'd0;
  localparam logic [1:0] MISC_MREQ  = 2'd1;
  localparam logic [1:0] MISC_TRIG0 = 2'd2;
  localparam logic [1:0] MISC_TRIG1 = 2'd3;

  typedef struct packed {
    logic [SLAVE_N-1:0] maskWr;
    logic [SLAVE_N-1:0] slaveEoi;
    logic               masterEoi;
    logic [1:0]         trigWr;
    logic               ack;
  } ctrl_strobes_t;

  // master input that each slave cascades into
  function automatic logic [IDX_W-1:0] masterInputOf(input logic [SLAVE_W-1:0] k);
    return (k == '0) ? IDX_W'(1) : IDX_W'(k) + IDX_W'(2);
  endfunction

  // sparse trigger-byte map onto tree lines
  function automatic logic [LINE_N-1:0] levelVector(input logic [DATA_W-1:0] lo,
                                                    input logic [TRIG_HI_W-1:0] hi);
    logic [LINE_N-1:0] v;
    v = '0;
    for (int j = 0; j < 5; j++) v[EISA_BASE + 3 + j] = lo[j];
    for (int j = 5; j < 8; j++) v[EISA_BASE + 4 + j] = lo[j];
    v[EISA_BASE + 12] = hi[0];
    for (int j = 1; j < 3; j++) v[EISA_BASE + 13 + j] = hi[j];
    return v;
  endfunction
endpackage

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter  int WIDTH = 8,
  localparam int IW    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reqVec,
  input  logic [WIDTH-1:0] inService,
  output logic             grantValid,
  output logic [IW-1:0]    grantIdx
);
  // fixed priority, index 0 highest; an in-service bit stops the scan
  always_comb begin
    logic stop;
    stop       = 1'b0;
    grantValid = 1'b0;
    grantIdx   = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!stop) begin
        if (inService[i]) begin
          stop = 1'b1;
        end else if (reqVec[i]) begin
          grantValid = 1'b1;
          grantIdx   = IW'(i);
          stop       = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
(
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [4:0]              eoiTag,
  input  logic                    ackStrobe,
  input  logic                    irqPending,
  output ctrl_strobes_t           strobes
);
  logic eoiOk;
  assign eoiOk = (eoiTag == EOI_TAG);

  always_comb begin
    strobes     = '0;
    strobes.ack = ackStrobe & irqPending;
    if (regWrEn) begin
      unique case (regAddr[3:2])
        GRP_MASK: strobes.maskWr[regAddr[1:0]]   = 1'b1;
        GRP_SCMD: strobes.slaveEoi[regAddr[1:0]] = eoiOk;
        GRP_MISC: begin
          unique case (regAddr[1:0])
            MISC_MCMD:  strobes.masterEoi = eoiOk;
            MISC_TRIG0: strobes.trigWr[0] = 1'b1;
            MISC_TRIG1: strobes.trigWr[1] = 1'b1;
            default:    ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_tree_datapath.sv
module irq_tree_datapath
  import irq_tree_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [LINE_N-1:0]   reqLines,
  input  logic                bridgeReq,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut,
  output logic                irqFromBridge,
  output logic [LINE_W-1:0]   irqLine
);
  logic [LINE_N-1:0]    maskFlat;
  logic [LINE_N-1:0]    slaveIsrFlat;
  logic [UNIT_W-1:0]    masterIsr;
  logic [DATA_W-1:0]    trigLo;
  logic [TRIG_HI_W-1:0] trigHi;
  logic [LINE_N-1:0]    edgeLatch;
  logic [LINE_N-1:0]    prevIn;

  logic [LINE_N-1:0]    levelVec, riseVec, pendRaw, ackClr, edgeLatchNext;
  logic [LINE_N-1:0]    slaveIsrNext;
  logic [UNIT_W-1:0]    masterIsrNext, masterReqVec;
  logic [SLAVE_N-1:0]   sValid;
  logic [IDX_W-1:0]     sIdx [SLAVE_N];
  logic                 mValid;
  logic [IDX_W-1:0]     mIdx;
  logic                 winIsSlave;
  logic [SLAVE_W-1:0]   winSlave;

  assign levelVec = levelVector(trigLo, trigHi);
  assign riseVec  = reqLines & ~prevIn;
  assign pendRaw  = (edgeLatch & ~levelVec) | (reqLines & levelVec);

  // slave priority units
  for (genvar k = 0; k < SLAVE_N; k++) begin : g_slave
    irq_prio_unit #(.WIDTH(UNIT_W)) u_slavePrio (
      .reqVec     (pendRaw[k*UNIT_W +: UNIT_W] & ~maskFlat[k*UNIT_W +: UNIT_W]),
      .inService  (slaveIsrFlat[k*UNIT_W +: UNIT_W]),
      .grantValid (sValid[k]),
      .grantIdx   (sIdx[k])
    );
  end

  always_comb begin
    masterReqVec    = '0;
    masterReqVec[0] = bridgeReq;
    for (int k = 0; k < SLAVE_N; k++)
      masterReqVec[masterInputOf(SLAVE_W'(k))] = sValid[k];
  end

  irq_prio_unit #(.WIDTH(UNIT_W)) u_masterPrio (
    .reqVec     (masterReqVec),
    .inService  (masterIsr),
    .grantValid (mValid),
    .grantIdx   (mIdx)
  );

  always_comb begin
    winIsSlave = 1'b0;
    winSlave   = '0;
    for (int k = 0; k < SLAVE_N; k++) begin
      if (masterInputOf(SLAVE_W'(k)) == mIdx) begin
        winIsSlave = mValid;
        winSlave   = SLAVE_W'(k);
      end
    end
  end

  assign irqOut        = mValid;
  assign irqFromBridge = mValid && (mIdx == '0);
  assign irqLine       = winIsSlave ? {winSlave, sIdx[winSlave]} : '0;

  // next state of in-service and latch state; acknowledge wins over retire
  always_comb begin
    slaveIsrNext  = slaveIsrFlat;
    masterIsrNext = masterIsr;
    ackClr        = '0;
    for (int k = 0; k < SLAVE_N; k++)
      if (strobes.slaveEoi[k]) slaveIsrNext[k*UNIT_W + int'(wrData[IDX_W-1:0])] = 1'b0;
    if (strobes.masterEoi) masterIsrNext[wrData[IDX_W-1:0]] = 1'b0;
    if (strobes.ack) begin
      masterIsrNext[mIdx] = 1'b1;
      if (winIsSlave) begin
        slaveIsrNext[irqLine] = 1'b1;
        ackClr[irqLine]       = 1'b1;
      end
    end
    edgeLatchNext = ((edgeLatch & ~ackClr) | riseVec) & ~levelVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskFlat     <= '1;
      slaveIsrFlat <= '0;
      masterIsr    <= '0;
      trigLo       <= '0;
      trigHi       <= '0;
      edgeLatch    <= '0;
      prevIn       <= '0;
    end else begin
      for (int k = 0; k < SLAVE_N; k++)
        if (strobes.maskWr[k]) maskFlat[k*UNIT_W +: UNIT_W] <= wrData;
      if (strobes.trigWr[0]) trigLo <= wrData;
      if (strobes.trigWr[1]) trigHi <= wrData[TRIG_HI_W-1:0];
      slaveIsrFlat <= slaveIsrNext;
      masterIsr    <= masterIsrNext;
      edgeLatch    <= edgeLatchNext;
      prevIn       <= reqLines;
    end
  end

  // register read mux
  always_comb begin
    int sel;
    sel = int'(rdAddr[1:0]);
    unique case (rdAddr[3:2])
      GRP_MASK: rdData = maskFlat[sel*UNIT_W +: UNIT_W];
      GRP_SCMD: rdData = slaveIsrFlat[sel*UNIT_W +: UNIT_W];
      GRP_PEND: rdData = pendRaw[sel*UNIT_W +: UNIT_W];
      default: begin
        unique case (rdAddr[1:0])
          MISC_MCMD:  rdData = masterIsr;
          MISC_MREQ:  rdData = masterReqVec;
          MISC_TRIG0: rdData = trigLo;
          default:    rdData = {{(DATA_W-TRIG_HI_W){1'b0}}, trigHi};
        endcase
      end
    endcase
  end
endmodule

// File: rtl/irq_cascade_tree.sv
module irq_cascade_tree
  import irq_tree_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINE_N-1:0]   reqLines,
  input  logic                bridgeReq,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                ackStrobe,
  output logic                irqOut,
  output logic                irqFromBridge,
  output logic [LINE_W-1:0]   irqLine
);
  ctrl_strobes_t strobes;

  irq_tree_ctrl u_ctrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .eoiTag     (regWrData[7:3]),
    .ackStrobe  (ackStrobe),
    .irqPending (irqOut),
    .strobes    (strobes)
  );

  irq_tree_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (regWrData),
    .rdAddr        (regAddr),
    .reqLines      (reqLines),
    .bridgeReq     (bridgeReq),
    .rdData        (regRdData),
    .irqOut        (irqOut),
    .irqFromBridge (irqFromBridge),
    .irqLine       (irqLine)
  );
endmodule

// File: rtl/irq_tree_checker.sv
module irq_tree_checker
  import irq_tree_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                irqOut,
  input logic                irqFromBridge,
  input logic [LINE_W-1:0]   irqLine,
  input logic                ackGated,
  input logic                slaveEoi0,
  input logic [IDX_W-1:0]    eoiIdx,
  input logic [LINE_N-1:0]   slaveIsrFlat,
  input logic [UNIT_W-1:0]   masterIsr,
  input logic [LINE_N-1:0]   maskFlat
);
  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqFromBridge) |-> !maskFlat[irqLine]);

  assert_bridge_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqFromBridge |-> (irqOut && !masterIsr[0]));

  assert_ack_in_service_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackGated && irqOut && !irqFromBridge) |=> slaveIsrFlat[$past(irqLine)]);

  assert_slave_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqFromBridge) |-> !slaveIsrFlat[irqLine]);

  assert_master_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqFromBridge) |-> !masterIsr[masterInputOf(irqLine[LINE_W-1:IDX_W])]);

  assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (slaveEoi0 && !ackGated) |=> !slaveIsrFlat[$past(eoiIdx)]);
endmodule

bind irq_tree_datapath irq_tree_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .irqOut        (irqOut),
  .irqFromBridge (irqFromBridge),
  .irqLine       (irqLine),
  .ackGated      (strobes.ack),
  .slaveEoi0     (strobes.slaveEoi[0]),
  .eoiIdx        (wrData[2:0]),
  .slaveIsrFlat  (slaveIsrFlat),
  .masterIsr     (masterIsr),
  .maskFlat      (maskFlat)
);

// File: tb/irq_cascade_tree_bench.sv
`timescale 1ns/1ps
module irq_cascade_tree_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] reqLines;
  logic        bridgeReq;
  logic        regWrEn;
  logic [3:0]  regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData;
  logic        ackStrobe;
  logic        irqOut;
  logic        irqFromBridge;
  logic [4:0]  irqLine;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_cascade_tree u_irq_cascade_tree (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .bridgeReq(bridgeReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ackStrobe(ackStrobe), .irqOut(irqOut),
    .irqFromBridge(irqFromBridge), .irqLine(irqLine)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int masterIn(int k);
    return (k == 0) ? 1 : k + 2;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    regAddr = 4'(a); regWrData = 8'(d); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(int a, int exp, string tag);
    @(negedge clk);
    regAddr = 4'(a);
    #1;
    check(int'(regRdData) == exp, tag, int'(regRdData), exp);
  endtask

  task automatic ack();
    @(negedge clk); ackStrobe = 1'b1;
    @(negedge clk); ackStrobe = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); reqLines[n] = 1'b1;
    @(negedge clk); reqLines[n] = 1'b0;
  endtask

  // -1 encodes "no request"
  task automatic sampleIrq(bit on, int line, string tag);
    int act, exp;
    act = irqOut ? int'(irqLine) : -1;
    exp = on ? line : -1;
    check(act == exp && (!on || !irqFromBridge), tag, act, exp);
  endtask

  task automatic expectIrq(bit on, int line, string tag);
    @(negedge clk); #1;
    sampleIrq(on, line, tag);
  endtask

  task automatic eoiLine(int n);
    wr(4 + (n >> 3), 'hE0 | (n & 7));
    wr(8, 'hE0 | masterIn(n >> 3));
  endtask

  function automatic int levelLineOfBit(int j);
    int eisa;
    if (j < 5)      eisa = 3 + j;
    else if (j < 8) eisa = 4 + j;
    else if (j == 8) eisa = 12;
    else            eisa = 13 + (j - 8);
    return eisa + 7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqLines = '0; bridgeReq = 1'b0; regWrEn = 1'b0;
    regAddr = '0; regWrData = '0; ackStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int k = 0; k < 4; k++) rdCheck(k, 'hFF, "R1 mask reset");
    for (int a = 4; a <= 8; a++) rdCheck(a, 0, "R1 in-service reset");
    rdCheck(10, 0, "R1 trigger byte 0 reset");
    rdCheck(11, 0, "R1 trigger byte 1 reset");
    pulse(20);
    expectIrq(1'b0, 0, "R1 no request after reset");
    rdCheck(14, 'h10, "R3 masked edge latched line 20");
    wr(2, 'hEF);
    expectIrq(1'b1, 20, "R3 unmask single bit line 20");
    ack(); eoiLine(20); wr(2, 'hFF);

    // R3 masked latch, then unmask
    pulse(9);
    expectIrq(1'b0, 0, "R3 masked line 9 silent");
    rdCheck(13, 'h02, "R3 pending shows masked line 9");
    wr(1, 0);
    expectIrq(1'b1, 9, "R3 unmasked line 9 requests");
    ack();
    expectIrq(1'b0, 0, "R7 request drops after ack");
    eoiLine(9);
    for (int k = 0; k < 4; k++) wr(k, 0);

    // R7 ack with nothing pending is ignored
    ack();
    rdCheck(8, 0, "R7 idle ack leaves master in-service clear");
    for (int k = 0; k < 4; k++) rdCheck(4 + k, 0, "R7 idle ack leaves slave in-service clear");

    // R2/R4/R9 single-line sweep
    for (int n = 0; n < 32; n++) begin
      pulse(n);
      expectIrq(1'b1, n, "R4 edge latched after input falls");
      ack();
      expectIrq(1'b0, 0, "R7 in service after ack");
      rdCheck(4 + (n >> 3), 1 << (n & 7), "R2 slave in-service bit");
      rdCheck(8, 1 << masterIn(n >> 3), "R2 master in-service bit");
      rdCheck(12 + (n >> 3), 0, "R7 edge latch cleared by ack");
      wr(4 + (n >> 3), 'hE0 | (n & 7));
      rdCheck(4 + (n >> 3), 0, "R9 slave retire clears bit");
      rdCheck(8, 1 << masterIn(n >> 3), "R8 master bit kept after slave retire");
      wr(8, 'hE0 | masterIn(n >> 3));
      rdCheck(8, 0, "R9 master retire clears bit");
    end

    // R9 malformed command bytes ignored
    pulse(3); ack();
    wr(4, 'hE8); wr(4, 'h63); wr(4, 'hE4);
    rdCheck(4, 'h08, "R9 non-matching commands ignored");
    eoiLine(3);
    rdCheck(4, 0, "R9 matching command clears");

    // R6/R8 all ordered pairs
    for (int a = 0; a < 32; a++) begin
      for (int b = a + 1; b < 32; b++) begin
        @(negedge clk); reqLines[a] = 1'b1; reqLines[b] = 1'b1;
        @(negedge clk); reqLines[a] = 1'b0; reqLines[b] = 1'b0;
        expectIrq(1'b1, a, "R6 lower line wins");
        ack();
        expectIrq(1'b0, 0, "R8 lower priority blocked while in service");
        wr(4 + (a >> 3), 'hE0 | (a & 7));
        expectIrq(1'b0, 0, "R8 still blocked until master retire");
        wr(8, 'hE0 | masterIn(a >> 3));
        expectIrq(1'b1, b, "R8 second line after full retire");
        ack(); eoiLine(b);
        expectIrq(1'b0, 0, "R9 idle after both retired");
      end
    end

    // R6 bridge input
    pulse(0);
    @(negedge clk); bridgeReq = 1'b1;
    #1;
    check(irqOut && irqFromBridge, "R6 bridge beats tree line",
          int'({irqOut, irqFromBridge}), 3);
    ack();
    expectIrq(1'b0, 0, "R8 bridge in service blocks tree");
    rdCheck(8, 'h01, "R2 bridge sets master bit 0");
    rdCheck(9, 'h03, "R10 master request vector bridge and slave 0");
    @(negedge clk); bridgeReq = 1'b0;
    wr(8, 'hE0);
    expectIrq(1'b1, 0, "R6 tree line after bridge retire");
    ack(); eoiLine(0);

    // R5 trigger byte readback
    wr(11, 'hFF);
    rdCheck(11, 'h07, "R5 unused trigger bits read zero");
    wr(10, 'hA5);
    rdCheck(10, 'hA5, "R10 trigger byte 0 readback");

    // R5 each trigger bit against each line
    for (int j = 0; j < 11; j++) begin
      int lv;
      lv = levelLineOfBit(j);
      wr(10, (j < 8) ? (1 << j) : 0);
      wr(11, (j >= 8) ? (1 << (j - 8)) : 0);
      for (int n = 0; n < 32; n++) begin
        @(negedge clk); reqLines[n] = 1'b1;
        expectIrq(1'b1, n, "R5 request while input high");
        reqLines[n] = 1'b0;
        #1;
        if (n == lv) begin
          sampleIrq(1'b0, 0, "R5 level line drops with input");
        end else begin
          sampleIrq(1'b1, n, "R4 edge line holds after input falls");
          ack(); eoiLine(n);
        end
      end
    end

    // R5 level line re-requests after retire while still high
    wr(10, 'h01); wr(11, 0);
    @(negedge clk); reqLines[10] = 1'b1;
    expectIrq(1'b1, 10, "R5 level line 10 requests");
    ack();
    expectIrq(1'b0, 0, "R7 level line in service");
    eoiLine(10);
    expectIrq(1'b1, 10, "R5 level line requests again after retire");
    reqLines[10] = 1'b0;
    #1;
    sampleIrq(1'b0, 0, "R5 level line released");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule